// File: doc/BRIEF.md
# Host Port Transfer Sequencer

This block takes one 32-bit read or write request from the target side of a bridge. It runs the request as a pair of narrow cycles on the host port of an attached signal processor. One request names the target device (one of up to four), the port width of that device (8-bit or 16-bit), the access kind and the data.

The sequencer selects the device, presents the register-select code, the upper/lower-part flag, the read/write level and the byte enables. One setup cycle later it raises the data strobe. It then keeps the strobe high until that device reports ready. Written data goes out lowest part first. Read parts are gathered into one word in the same order. When the second part finishes, the select drops and a done pulse lasts one clock.

The access kind is taken from two address bits: 0 = control, 1 = address, 2 = data with post-increment, 3 = data without increment. The sequencer turns the kind into the register-select code that suits the device's port width.

Top module: `hpi_seq`

## Requirements
- R1: An accepted request produces exactly two strobe phases. The cycle after the second phase ends, `rsp_done` is high for exactly one clock while `hp_cs` is all zero and `hp_strobe` is low.
- R2: `hp_upper` is 0 during the first phase of a pair and 1 during the second.
- R3: On writes in 16-bit mode, `hp_data` carries `req_wdata[15:0]` and then `req_wdata[31:16]`. In 8-bit mode it carries `req_wdata[7:0]` and then `req_wdata[15:8]` on `hp_data[7:0]`, with `hp_data[15:8]` at 0.
- R4: In 8-bit mode, `hp_sel` is 00 for kind control, 10 for kind address, 01 for kind data with increment and 11 for kind data without increment. The kind is `req_addr[3:2]`.
- R5: In 16-bit mode (`req_wide`=1), `hp_sel` equals the kind: 00 control, 01 address, 10 data with increment, 11 data without increment.
- R6: `hp_sel`, `hp_upper` and `hp_rnw` are set at least one cycle before `hp_strobe` rises. They stay stable while the strobe is high.
- R7: While the strobe is high, the phase ends only on a clock where the `hp_rdy` bit of the selected device is 1. The strobe then lasts exactly the number of not-ready cycles plus one. The ready bits of other devices have no effect.
- R8: An 8-bit-mode write of kind control sends `req_wdata[7:0]` in both phases.
- R9: `hp_cs` is one-hot at bit `req_dev` for the whole transfer and is all zero when idle and after reset.
- R10: On reads, `rsp_rdata` holds `{second,first}` 16-bit parts in 16-bit mode. In 8-bit mode it holds `{16'h0, second[7:0], first[7:0]}`. The value stays valid from `rsp_done` until the next accepted request.
- R11: `hp_be` (active high) is `req_be[1:0]` and then `req_be[3:2]` in 16-bit mode. In 8-bit mode it is `{0,req_be[0]}` and then `{0,req_be[1]}`.
- R12: `req_valid` is ignored while a transfer is in progress. The chip select stays on the first device and no second transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit port, 0 = 8-bit port |
| req_dev | input | 2 | Target device index |
| req_addr | input | 8 | Request address; bits 3:2 give the access kind |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables of the word |
| rsp_rdata | output | 32 | Assembled read data |
| rsp_done | output | 1 | One-clock completion pulse |
| hp_cs | output | 4 | Per-device chip selects, active high |
| hp_sel | output | 2 | Register-select code |
| hp_upper | output | 1 | Second-part flag |
| hp_strobe | output | 1 | Data strobe, active high |
| hp_rnw | output | 1 | 1 = read, 0 = write |
| hp_be | output | 2 | Byte enables of the current part |
| hp_data | inout | 16 | Bidirectional port data |
| hp_rdy | input | 4 | Per-device ready |

## Verification
The checker watches these rules on every clock:
- select one-hot-or-zero and always present under the strobe;
- select code, part flag and direction held while the strobe is high;
- the strobe kept up while the selected device is not ready;
- a single-clock done with the port released;
- the upper-part flag set on the phase just before done.

Only the bench scenarios show the rest:
- the code chosen for each kind in each port width;
- the order of data parts and byte enables;
- the repeated byte of a narrow control write;
- the exact strobe length under injected wait states;
- the read assembly;
- that requests raised mid-transfer and ready bits of idle devices change nothing.

// File: rtl/hpi_seq_pkg.sv
package hpi_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_DONE   = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    K_CTRL     = 2'd0,
    K_ADDR     = 2'd1,
    K_DATA_INC = 2'd2,
    K_DATA_FIX = 2'd3
  } acc_kind_t;

  // Register-select code for an access kind and port width.
  function automatic logic [1:0] sel_code(input logic wide, input logic [1:0] kind);
    logic [1:0] c;
    if (wide) begin
      c = kind;
    end else begin
      case (kind)
        K_CTRL:     c = 2'b00;
        K_ADDR:     c = 2'b10;
        K_DATA_INC: c = 2'b01;
        default:    c = 2'b11;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/hpi_seq_fsm.sv
module hpi_seq_fsm
  import hpi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       rdy_sel,
  output seq_state_t state,
  output logic       part,
  output logic       accept,
  output logic       cap
);

  seq_state_t state_nx;
  logic       part_nx;

  assign accept = (state == ST_IDLE) && start;
  assign cap    = (state == ST_STROBE) && rdy_sel;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (start) state_nx = ST_SETUP;
      ST_SETUP:  state_nx = ST_STROBE;
      ST_STROBE: if (rdy_sel) state_nx = part ? ST_DONE : ST_SETUP;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    part_nx = part;
    if (accept)          part_nx = 1'b0;
    else if (cap && !part) part_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      part  <= 1'b0;
    end else begin
      state <= state_nx;
      part  <= part_nx;
    end
  end

endmodule

// File: rtl/hpi_seq_csdec.sv
module hpi_seq_csdec #(
  parameter int NUM_DEV = 4,
  localparam int DEV_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic               active,
  input  logic [DEV_W-1:0]   dev,
  input  logic [NUM_DEV-1:0] rdy,
  output logic [NUM_DEV-1:0] cs,
  output logic               rdy_sel
);

  for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
    assign cs[i] = active && (dev == DEV_W'(i));
  end

  assign rdy_sel = |(cs & rdy);

endmodule

// File: rtl/hpi_seq_lane.sv
module hpi_seq_lane
  import hpi_seq_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int PORT_W = WORD_W / 2,
  localparam int BYTE_W = PORT_W / 2,
  localparam int BE_W   = WORD_W / 8,
  localparam int PBE_W  = BE_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              cap,
  input  logic              part,
  input  logic              wide,
  input  logic              write,
  input  logic [1:0]        kind,
  input  logic [WORD_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  input  logic [PORT_W-1:0] din,
  output logic [PORT_W-1:0] dout,
  output logic [PBE_W-1:0]  pbe,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] acc_q, acc_nx;
  logic              acc_en;
  logic              repeat_low;

  // Narrow control writes repeat the low byte.
  assign repeat_low = (kind == K_CTRL) && write;

  always_comb begin
    if (wide) begin
      dout = part ? wdata[WORD_W-1:PORT_W] : wdata[PORT_W-1:0];
      pbe  = part ? be[BE_W-1:PBE_W] : be[PBE_W-1:0];
    end else begin
      dout = '0;
      dout[BYTE_W-1:0] = (part && !repeat_low) ? wdata[PORT_W-1:BYTE_W] : wdata[BYTE_W-1:0];
      pbe  = '0;
      pbe[0] = part ? be[1] : be[0];
    end
  end

  assign acc_en = accept || (cap && !write);

  always_comb begin
    acc_nx = acc_q;
    if (accept) begin
      acc_nx = '0;
    end else if (wide) begin
      if (part) acc_nx[WORD_W-1:PORT_W] = din;
      else      acc_nx[PORT_W-1:0]      = din;
    end else begin
      if (part) acc_nx[PORT_W-1:BYTE_W] = din[BYTE_W-1:0];
      else      acc_nx[BYTE_W-1:0]      = din[BYTE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_nx;
  end

  assign rdata = acc_q;

endmodule

// File: rtl/hpi_seq.sv
module hpi_seq
  import hpi_seq_pkg::*;
#(
  parameter int NUM_DEV  = 4,
  parameter int ADDR_W   = 8,
  parameter int KIND_LSB = 2,
  parameter int WORD_W   = 32,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int PORT_W = WORD_W / 2,
  localparam int BE_W   = WORD_W / 8,
  localparam int PBE_W  = BE_W / 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic               req_wide,
  input  logic [DEV_W-1:0]   req_dev,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [WORD_W-1:0]  req_wdata,
  input  logic [BE_W-1:0]    req_be,
  output logic [WORD_W-1:0]  rsp_rdata,
  output logic               rsp_done,
  output logic [NUM_DEV-1:0] hp_cs,
  output logic [1:0]         hp_sel,
  output logic               hp_upper,
  output logic               hp_strobe,
  output logic               hp_rnw,
  output logic [PBE_W-1:0]   hp_be,
  inout  wire  [PORT_W-1:0]  hp_data,
  input  logic [NUM_DEV-1:0] hp_rdy
);

  seq_state_t        state;
  logic              part, accept, cap, rdy_sel, active;
  logic [DEV_W-1:0]  r_dev;
  logic              r_write, r_wide;
  logic [1:0]        r_kind;
  logic [WORD_W-1:0] r_wdata;
  logic [BE_W-1:0]   r_be;
  logic [PORT_W-1:0] dout;

  // Request capture, enabled only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_dev   <= '0;
      r_write <= 1'b0;
      r_wide  <= 1'b0;
      r_kind  <= '0;
      r_wdata <= '0;
      r_be    <= '0;
    end else if (accept) begin
      r_dev   <= req_dev;
      r_write <= req_write;
      r_wide  <= req_wide;
      r_kind  <= req_addr[KIND_LSB+1:KIND_LSB];
      r_wdata <= req_wdata;
      r_be    <= req_be;
    end
  end

  hpi_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (req_valid),
    .rdy_sel (rdy_sel),
    .state   (state),
    .part    (part),
    .accept  (accept),
    .cap     (cap)
  );

  assign active = (state == ST_SETUP) || (state == ST_STROBE);

  hpi_seq_csdec #(.NUM_DEV(NUM_DEV)) u_csdec (
    .active  (active),
    .dev     (r_dev),
    .rdy     (hp_rdy),
    .cs      (hp_cs),
    .rdy_sel (rdy_sel)
  );

  hpi_seq_lane #(.WORD_W(WORD_W)) u_lane (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .cap    (cap),
    .part   (part),
    .wide   (r_wide),
    .write  (r_write),
    .kind   (r_kind),
    .wdata  (r_wdata),
    .be     (r_be),
    .din    (hp_data),
    .dout   (dout),
    .pbe    (hp_be),
    .rdata  (rsp_rdata)
  );

  assign hp_sel    = sel_code(r_wide, r_kind);
  assign hp_upper  = part;
  assign hp_strobe = (state == ST_STROBE);
  assign hp_rnw    = !r_write;
  assign rsp_done  = (state == ST_DONE);
  assign hp_data   = (active && r_write) ? dout : 'z;

endmodule

// File: rtl/hpi_seq_chk.sv
module hpi_seq_chk #(
  parameter int NUM_DEV = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rsp_done,
  input logic [NUM_DEV-1:0] hp_cs,
  input logic [1:0]         hp_sel,
  input logic               hp_upper,
  input logic               hp_strobe,
  input logic               hp_rnw,
  input logic [NUM_DEV-1:0] hp_rdy
);

  a_r9_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hp_cs));

  a_r9_cs_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    hp_strobe |-> (hp_cs != '0));

  a_r6_stable_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    hp_strobe |-> ($stable(hp_sel) && $stable(hp_upper) && $stable(hp_rnw)));

  a_r6_setup_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hp_strobe) |-> $past(hp_cs != '0));

  a_r7_hold_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_strobe && ((hp_cs & hp_rdy) == '0)) |=> (hp_strobe && $stable(hp_upper)));

  a_r1_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ((hp_cs == '0) && !hp_strobe));

  a_r1_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r2_upper_last: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(hp_upper));

endmodule

bind hpi_seq hpi_seq_chk #(.NUM_DEV(NUM_DEV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rsp_done  (rsp_done),
  .hp_cs     (hp_cs),
  .hp_sel    (hp_sel),
  .hp_upper  (hp_upper),
  .hp_strobe (hp_strobe),
  .hp_rnw    (hp_rnw),
  .hp_rdy    (hp_rdy)
);

// File: tb/hpi_seq_bench.sv
`timescale 1ns/1ps
module hpi_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_wide;
  logic [1:0]  req_dev;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic [3:0]  req_be;
  logic [31:0] rsp_rdata;
  logic        rsp_done;
  logic [3:0]  hp_cs;
  logic [1:0]  hp_sel;
  logic        hp_upper, hp_strobe, hp_rnw;
  logic [1:0]  hp_be;
  wire  [15:0] hp_data;
  logic [3:0]  hp_rdy;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  hpi_seq u_hpi_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_dev(req_dev), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .hp_cs(hp_cs), .hp_sel(hp_sel), .hp_upper(hp_upper),
    .hp_strobe(hp_strobe), .hp_rnw(hp_rnw), .hp_be(hp_be), .hp_data(hp_data),
    .hp_rdy(hp_rdy)
  );

  // Device model: programmable wait states, read data, phase log.
  logic [1:0]  wait_set = 2'd0;
  logic [1:0]  wcnt;
  logic [15:0] rd_lo = 16'h0, rd_hi = 16'h0;

  always @(posedge clk) begin
    if (!hp_strobe) wcnt <= wait_set;
    else if (wcnt != 2'd0) wcnt <= wcnt - 2'd1;
  end

  always_comb begin
    for (int i = 0; i < 4; i++) hp_rdy[i] = hp_cs[i] ? (wcnt == 2'd0) : 1'b1;
  end

  assign hp_data = ((hp_cs != 4'd0) && hp_rnw) ? (hp_upper ? rd_hi : rd_lo) : 16'hzzzz;

  logic [1:0]  lg_sel [2];
  logic        lg_up  [2];
  logic        lg_rnw [2];
  logic [15:0] lg_dat [2];
  logic [1:0]  lg_be  [2];
  logic [3:0]  lg_cs  [2];
  int          lg_len [2];
  int          lg_total = 0;
  int          scnt = 0;

  always @(posedge clk) begin
    if (hp_strobe) begin
      if ((hp_cs & hp_rdy) != 4'd0) begin
        lg_sel[lg_total & 1] <= hp_sel;
        lg_up [lg_total & 1] <= hp_upper;
        lg_rnw[lg_total & 1] <= hp_rnw;
        lg_dat[lg_total & 1] <= hp_data;
        lg_be [lg_total & 1] <= hp_be;
        lg_cs [lg_total & 1] <= hp_cs;
        lg_len[lg_total & 1] <= scnt + 1;
        lg_total <= lg_total + 1;
        scnt <= 0;
      end else begin
        scnt <= scnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_sel(input bit wide, input int kind);
    if (wide) return 2'(kind);
    case (kind)
      0: return 2'b00;
      1: return 2'b10;
      2: return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

  function automatic logic [15:0] exp_wd(input bit wide, input int kind, input int p, input logic [31:0] wd);
    if (wide) return p ? wd[31:16] : wd[15:0];
    return {8'h00, (p != 0 && kind != 0) ? wd[15:8] : wd[7:0]};
  endfunction

  function automatic logic [1:0] exp_be(input bit wide, input int p, input logic [3:0] be);
    if (wide) return p ? be[3:2] : be[1:0];
    return {1'b0, p ? be[1] : be[0]};
  endfunction

  function automatic logic [31:0] exp_rd(input bit wide, input logic [15:0] lo, input logic [15:0] hi);
    if (wide) return {hi, lo};
    return {16'h0, hi[7:0], lo[7:0]};
  endfunction

  task automatic xfer(input int dev, input bit wide, input bit wr, input int kind,
                      input logic [31:0] wd, input logic [3:0] be,
                      input logic [15:0] rlo, input logic [15:0] rhi,
                      input int wt, input bit poke);
    int base;
    int n;
    @(negedge clk);
    rd_lo = rlo; rd_hi = rhi; wait_set = 2'(wt);
    req_dev = 2'(dev); req_wide = wide; req_write = wr;
    req_addr = {4'h0, 2'(kind), 2'b00}; req_wdata = wd; req_be = be;
    req_valid = 1'b1;
    base = lg_total;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      req_dev = 2'(dev ^ 1); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (!rsp_done && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_done == 1'b1, "R1 done seen", 32'(rsp_done), 32'd1);
    chk(hp_cs == 4'd0 && !hp_strobe, "R1 released at done", 32'(hp_cs), 32'd0);
    chk(lg_total - base == 2, "R1 two phases", 32'(lg_total - base), 32'd2);
    for (int p = 0; p < 2; p++) begin
      chk(lg_up[p] == 1'(p), "R2 upper flag", 32'(lg_up[p]), 32'(p));
      chk(lg_sel[p] == exp_sel(wide, kind), wide ? "R5 select code" : "R4 select code",
          32'(lg_sel[p]), 32'(exp_sel(wide, kind)));
      chk(lg_cs[p] == 4'(1 << dev), "R9 chip select", 32'(lg_cs[p]), 32'(1 << dev));
      chk(lg_len[p] == wt + 1, "R7 strobe length", 32'(lg_len[p]), 32'(wt + 1));
      chk(lg_rnw[p] == !wr, "R6 direction", 32'(lg_rnw[p]), 32'(!wr));
      chk(lg_be[p] == exp_be(wide, p, be), "R11 byte enables", 32'(lg_be[p]), 32'(exp_be(wide, p, be)));
      if (wr)
        chk(lg_dat[p] == exp_wd(wide, kind, p, wd), (!wide && kind == 0) ? "R8 control byte" : "R3 write data",
            32'(lg_dat[p]), 32'(exp_wd(wide, kind, p, wd)));
    end
    if (!wr) chk(rsp_rdata == exp_rd(wide, rlo, rhi), "R10 read data", rsp_rdata, exp_rd(wide, rlo, rhi));
    @(negedge clk);
    chk(rsp_done == 1'b0, "R1 done one clock", 32'(rsp_done), 32'd0);
    if (!wr) chk(rsp_rdata == exp_rd(wide, rlo, rhi), "R10 read data held", rsp_rdata, exp_rd(wide, rlo, rhi));
    if (poke) begin
      @(negedge clk);
      chk(hp_cs == 4'd0 && lg_total - base == 2, "R12 busy request ignored", 32'(hp_cs), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4321));
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
    req_dev = 2'd0; req_addr = 8'h0; req_wdata = 32'h0; req_be = 4'h0;
    repeat (4) @(negedge clk);
    chk(hp_cs == 4'd0, "R9 reset chip select", 32'(hp_cs), 32'd0);
    chk(!hp_strobe && !rsp_done, "R1 reset idle", {30'd0, hp_strobe, rsp_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: every kind, both widths, writes.
    for (int k = 0; k < 4; k++) begin
      xfer(k, 1'b1, 1'b1, k, 32'hA1B2C3D4 + 32'(k), 4'b1011, 16'h0, 16'h0, 0, 1'b0);
      xfer(k, 1'b0, 1'b1, k, 32'h5566E7F8 + 32'(k), 4'b0110, 16'h0, 16'h0, 1, 1'b0);
    end
    // R8: narrow control write repeats the low byte.
    xfer(2, 1'b0, 1'b1, 0, 32'h0000BBAA, 4'b0011, 16'h0, 16'h0, 0, 1'b0);
    // R10: reads in both widths, with waits.
    xfer(1, 1'b1, 1'b0, 2, 32'h0, 4'hF, 16'h1234, 16'h89AB, 2, 1'b0);
    xfer(3, 1'b0, 1'b0, 3, 32'h0, 4'h3, 16'hFFCC, 16'hEEDD, 3, 1'b0);
    // R7: longest wait; R12: request raised while busy.
    xfer(0, 1'b1, 1'b1, 3, 32'hDEADBEEF, 4'hF, 16'h0, 16'h0, 3, 1'b1);
    xfer(1, 1'b0, 1'b0, 1, 32'h0, 4'h3, 16'h7F01, 16'h80FE, 2, 1'b1);

    // Random mix.
    for (int i = 0; i < 60; i++) begin
      xfer(int'($urandom % 4), 1'($urandom), 1'($urandom), int'($urandom % 4), $urandom,
           4'($urandom), 16'($urandom), 16'($urandom), int'($urandom % 4), ($urandom % 5) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule